// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This controller connects a core that issues byte, word and long-word operand accesses to an external 16-bit data bus. The port it addresses may be 8 or 16 bits wide. The controller splits each operand into a sequence of bus cycles. For every cycle it presents the address, a two-bit code for the bytes still outstanding, and the write data steered onto the correct lanes. On reads it collects the returned bytes into a right-justified operand.

The slave sets the width of each cycle through an active-low acknowledge pair, so one operand may cross into a port of a different width and still complete. Operands are big-endian: the lowest address holds the most significant byte. Word and long-word requests at an odd address are refused with a one-clock error pulse, and no bus cycle is started.

Top module: `bus_sizer`

## Requirements
- R1: While reset is high, and in the clock after it, bus_cyc, done and addr_err are all low.
- R2: A word (req_size 10) or long (req_size 00) request with req_addr[0]=1 raises addr_err for exactly the one clock after it is taken. It starts no bus cycle and gives no done pulse. A byte request (req_size 01) at an odd address runs normally.
- R3: During every bus cycle, bus_siz holds the count of operand bytes not yet moved: 01 for 1, 10 for 2, 11 for 3, 00 for 4. bus_addr holds the request address plus the number of bytes already moved.
- R4: A long word to an 8-bit port takes four cycles, at addresses A, A+1, A+2 and A+3, with bus_siz 00, 11, 10 and 01.
- R5: A long word to a 16-bit port at an even address takes two cycles, at A and A+2, with bus_siz 00 and then 10.
- R6: ack_n[1] is the 16-bit acknowledge and ack_n[0] is the 8-bit acknowledge, both active low. The value 10 ends the cycle as an 8-bit port and 01 ends it as a 16-bit port. The value 00 is handled exactly like 01. The value 11 holds the cycle with the address and size unchanged.
- R7: A write cycle that moves one byte (one byte left, or an odd address) drives that byte on both bus_dout[15:8] and bus_dout[7:0]. With two or more bytes left at an even address, the next byte goes on [15:8] and the byte after it on [7:0].
- R8: On reads, an 8-bit port delivers its byte on bus_din[15:8]. A 16-bit port delivers the byte at an even address on [15:8] and the byte at an odd address on [7:0]. Lanes the port does not use are never merged into the result. rdata holds the operand right-justified, with the lowest-address byte most significant.
- R9: done is high for exactly one clock, in the clock after the last acknowledge, and rdata is valid while it is high. A request presented while a transfer is in progress is ignored. A request presented in the done clock is accepted.
- R10: A 16-bit acknowledge at an odd address moves one byte, and the address steps by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Operand request, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 01 byte, 10 word, 00 long word |
| req_addr | input | AW | Operand byte address |
| req_wdata | input | 32 | Write operand, right-justified |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read operand, right-justified |
| addr_err | output | 1 | One-clock misaligned-request pulse |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Direction of the current cycle |
| bus_addr | output | AW | Byte address of the current cycle |
| bus_siz | output | 2 | Bytes still outstanding, modulo 4 |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| ack_n | input | 2 | Acknowledge pair, active low: [1] 16-bit, [0] 8-bit |

## Verification
Two events can fall in the same clock: a completion (done together with the final rdata) and the acceptance of the next request. The bench holds req high from one transfer straight into the next and only changes the request fields in the done clock. While a transfer is running it fills the request fields with unrelated values. It then checks that the finished operand's data, address sequence and size codes belong only to the original request, and that the following transfer starts from the newly presented fields.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int BUS_W = 16;
  localparam int OPD_W = 32;

  typedef enum logic [1:0] {
    SZ_LONG   = 2'b00,
    SZ_BYTE   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_TRIPLE = 2'b11
  } siz_e;

  localparam logic [1:0] ACK_HOLD = 2'b11;
  localparam logic [1:0] ACK_NARROW = 2'b10;

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      SZ_TRIPLE: size_bytes = 3'd3;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bsz_step.sv
module bsz_step (
  input  logic [1:0] ack_n,
  input  logic       odd,
  input  logic [2:0] left,
  output logic       ack_any,
  output logic       narrow,
  output logic [2:0] take
);
  import bsz_pkg::*;
  always_comb begin
    ack_any = (ack_n != ACK_HOLD);
    narrow  = (ack_n == ACK_NARROW);
    take    = (narrow || odd || left == 3'd1) ? 3'd1 : 3'd2;
  end
endmodule

// File: rtl/bsz_wlane.sv
module bsz_wlane (
  input  logic [31:0] wbuf,
  input  logic        odd,
  input  logic [2:0]  left,
  output logic [15:0] dout
);
  always_comb begin
    if (odd || left == 3'd1) dout = {wbuf[31:24], wbuf[31:24]};
    else                     dout = wbuf[31:16];
  end
endmodule

// File: rtl/bsz_rpack.sv
module bsz_rpack (
  input  logic [31:0] rbuf,
  input  logic [15:0] din,
  input  logic        narrow,
  input  logic        odd,
  input  logic [2:0]  take,
  output logic [31:0] rbuf_nxt
);
  logic [7:0] one_byte;
  always_comb begin
    one_byte = (narrow || !odd) ? din[15:8] : din[7:0];
    if (take == 3'd2) rbuf_nxt = {rbuf[15:0], din};
    else              rbuf_nxt = {rbuf[23:0], one_byte};
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          addr_err,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic [15:0]   bus_dout,
  input  logic [15:0]   bus_din,
  input  logic [1:0]    ack_n
);
  import bsz_pkg::*;

  logic          busy_q, we_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    left_q;
  logic [31:0]   wbuf_q, rbuf_q, rdata_q;

  logic          ack_any, narrow;
  logic [2:0]    take, req_n;
  logic [31:0]   rbuf_nxt;
  logic          misaligned;

  bsz_step u_step (
    .ack_n(ack_n), .odd(addr_q[0]), .left(left_q),
    .ack_any(ack_any), .narrow(narrow), .take(take)
  );

  bsz_wlane u_wlane (
    .wbuf(wbuf_q), .odd(addr_q[0]), .left(left_q), .dout(bus_dout)
  );

  bsz_rpack u_rpack (
    .rbuf(rbuf_q), .din(bus_din), .narrow(narrow), .odd(addr_q[0]),
    .take(take), .rbuf_nxt(rbuf_nxt)
  );

  assign req_n      = size_bytes(req_size);
  assign misaligned = (req_size != SZ_BYTE) && req_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      left_q  <= 3'd0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (req) begin
          if (misaligned) begin
            err_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            we_q   <= req_we;
            addr_q <= req_addr;
            left_q <= req_n;
            rbuf_q <= '0;
            case (req_n)
              3'd1:    wbuf_q <= req_wdata << 24;
              3'd2:    wbuf_q <= req_wdata << 16;
              3'd3:    wbuf_q <= req_wdata << 8;
              default: wbuf_q <= req_wdata;
            endcase
          end
        end
      end else if (ack_any) begin
        rbuf_q <= rbuf_nxt;
        addr_q <= addr_q + AW'(take);
        left_q <= left_q - take;
        wbuf_q <= (take == 3'd2) ? (wbuf_q << 16) : (wbuf_q << 8);
        if (left_q == take) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= rbuf_nxt;
        end
      end
    end
  end

  assign done     = done_q;
  assign addr_err = err_q;
  assign rdata    = rdata_q;
  assign bus_cyc  = busy_q;
  assign bus_we   = we_q;
  assign bus_addr = addr_q;
  assign bus_siz  = left_q[1:0];

  a_r2_misaligned_refused: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && req && req_size != SZ_BYTE && req_addr[0]) |=> (addr_err && !bus_cyc && !done));

  a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && ack_n == ACK_HOLD) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_siz)));

  a_r4_narrow_long_step: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_siz == 2'b00 && ack_n == ACK_NARROW) |=>
      (bus_cyc && bus_siz == 2'b11 && bus_addr == $past(bus_addr) + AW'(1)));

  a_r5_wide_long_step: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_siz == 2'b00 && ack_n == 2'b01 && !bus_addr[0]) |=>
      (bus_cyc && bus_siz == 2'b10 && bus_addr == $past(bus_addr) + AW'(2)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_ends_cycle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_cyc && !addr_err));
endmodule

// File: tb/bus_sizer_test.sv
module bus_sizer_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [1:0]    req_size = 2'b01;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          done, addr_err, bus_cyc, bus_we;
  logic [31:0]   rdata;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic [1:0]    ack_n = 2'b11;

  int checks = 0;
  int failures = 0;
  logic [7:0]  mem  [64];
  logic [7:0]  gold [64];
  logic [15:0] rng = 16'hACE1;

  always #10 clk = ~clk;

  bus_sizer #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .addr_err(addr_err), .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_dout(bus_dout), .bus_din(bus_din), .ack_n(ack_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_rng();
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
  endtask

  function automatic logic [7:0] opd_byte(input logic [31:0] d, input int n, input int k);
    return d[8*(n-1-k) +: 8];
  endfunction

  function automatic logic [1:0] size_code(input int n);
    return (n == 1) ? 2'b01 : (n == 2) ? 2'b10 : 2'b00;
  endfunction

  task automatic xfer(input logic we, input int n, input logic [5:0] a, input logic [31:0] d);
    logic [AW-1:0] base;
    logic [5:0]    ca;
    logic [31:0]   exp;
    logic [15:0]   exp_dout;
    bit fin, misal, is8;
    int consumed, guard, waits, take, rem;
    base = 24'h120000 | AW'(a);
    misal = (n != 1) && a[0];
    consumed = 0; guard = 0; fin = 0; waits = 0;
    req = 1'b1; req_we = we; req_size = size_code(n); req_addr = base; req_wdata = d;
    @(negedge clk);
    while (!fin) begin
      guard++;
      if (guard > 60) begin
        chk("R9 watchdog transfer hung", 32'd1, 32'd0);
        fin = 1;
      end else if (misal) begin
        chk("R2 addr_err pulse", {31'd0, addr_err}, 32'd1);
        chk("R2 no bus cycle", {31'd0, bus_cyc}, 32'd0);
        chk("R2 no done", {31'd0, done}, 32'd0);
        ack_n = 2'b11;
        fin = 1;
      end else if (done) begin
        ack_n = 2'b11;
        chk("R9 done after all bytes", consumed, n);
        if (we) begin
          for (int k = 0; k < n; k++) begin
            chk("R7 memory byte after write", mem[6'(a + k)], opd_byte(d, n, k));
            gold[6'(a + k)] = opd_byte(d, n, k);
          end
        end else begin
          exp = 0;
          for (int k = 0; k < n; k++) exp = (exp << 8) | 32'(gold[6'(a + k)]);
          chk("R8 read operand", rdata, exp);
        end
        fin = 1;
      end else if (bus_cyc) begin
        req_addr = AW'({rng, rng}) | AW'(1);
        req_size = 2'b10;
        req_wdata = {rng, ~rng};
        if (waits > 0) begin
          ack_n = 2'b11;
          waits--;
        end else begin
          ca  = 6'(a + consumed);
          rem = n - consumed;
          is8 = (ca[5:4] < 2'd2);
          chk("R3 cycle address", bus_addr, base + AW'(consumed));
          chk("R3 size code", {30'd0, bus_siz}, {30'd0, 2'(rem)});
          chk("R9 direction latched", {31'd0, bus_we}, {31'd0, we});
          take = (is8 || ca[0] || rem == 1) ? 1 : 2;
          if (we) begin
            if (take == 1 && (ca[0] || rem == 1))
              exp_dout = {opd_byte(d, n, consumed), opd_byte(d, n, consumed)};
            else if (take == 1)
              exp_dout = {opd_byte(d, n, consumed), opd_byte(d, n, consumed + 1)};
            else
              exp_dout = {opd_byte(d, n, consumed), opd_byte(d, n, consumed + 1)};
            chk(ca[0] ? "R7 R10 odd write lanes" : "R7 write lanes", {16'd0, bus_dout}, {16'd0, exp_dout});
            if (take == 2) begin
              mem[ca] = bus_dout[15:8];
              mem[6'(ca + 1)] = bus_dout[7:0];
            end else if (is8) mem[ca] = bus_dout[15:8];
            else mem[ca] = ca[0] ? bus_dout[7:0] : bus_dout[15:8];
          end
          if (is8) bus_din = {mem[ca], 8'h5A ^ {2'b00, ca}};
          else bus_din = {mem[{ca[5:1], 1'b0}], mem[{ca[5:1], 1'b1}]};
          // R6: region 0-31 narrow (10), 32-47 wide (01), 48-63 wide via 00
          ack_n = is8 ? 2'b10 : (ca[4] ? 2'b00 : 2'b01);
          consumed += take;
          step_rng();
          waits = (rng[1:0] == 2'b11) ? 2 : int'(rng[0]);
        end
      end else begin
        chk("R9 transfer started", {31'd0, bus_cyc}, 32'd1);
        fin = 1;
      end
      if (!fin) @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]  = 8'(i * 37 + 11);
      gold[i] = mem[i];
    end
    ack_n = 2'b10;
    req = 1'b1; req_size = 2'b10; req_addr = 24'h000002;
    repeat (4) @(negedge clk);
    chk("R1 idle in reset bus_cyc", {31'd0, bus_cyc}, 32'd0);
    chk("R1 idle in reset done", {31'd0, done}, 32'd0);
    chk("R1 idle in reset addr_err", {31'd0, addr_err}, 32'd0);
    req = 1'b0; ack_n = 2'b11;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, bus_cyc, done, addr_err}, 32'd0);

    for (int si = 0; si < 3; si++) begin
      for (int a = 0; a < 64; a++) begin
        int n;
        n = (si == 0) ? 1 : (si == 1) ? 2 : 4;
        step_rng();
        xfer(1'b1, n, 6'(a), {rng, rng ^ 16'hA5C3});
        xfer(1'b0, n, 6'(a), 32'd0);
      end
    end
    req = 1'b0;
    @(negedge clk);
    chk("R9 idle at end", {31'd0, bus_cyc}, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule